// File: doc/BRIEF.md
# Rename Dispatch Credit Limiter

This block decides, once per cycle, how many of a thread's waiting instructions the rename stage may pass downstream. It keeps its own copies of the free-entry counts for the reorder buffer, the issue queue and the load/store queue. It also keeps two counters of instructions that were renamed but not yet dispatched: one for all instructions and one for memory instructions. Each free count is the stored credit, less the in-flight count, with the dispatch count reported this cycle added back. The smallest of the three free counts sets the credit budget, and the block reports which resource that was.

The candidate instructions arrive as an ordered group of slots. Each slot carries a squashed flag, a memory flag and a destination-register count. The block walks the slots in order. Squashed slots are removed at no cost. A live slot is renamed only while the credit budget, the rename width not already taken by other threads, and the free physical registers all allow it. The block reports the number renamed, the number removed, and a block flag when slots are left over. A per-resource full-event counter is kept as well.

Top module: `rename_credit_limiter`

## Requirements
- R1: After reset the reorder-buffer, issue-queue and load/store credits hold their parameter reset values. Both in-flight counters and all three full-event counters are zero, and the reorder-buffer-empty flag is 1.
- R2: A credit copy is replaced on the next clock edge by its update value only when its own update-valid input is high. Otherwise it keeps its value. A reorder-buffer update also loads the empty flag.
- R3: The reorder-buffer and issue-queue free counts are each computed as credit − (in-flight − disp_cnt). The load/store free count is computed as credit − (memory in-flight − disp_mem_cnt). All three are signed.
- R4: lim_src names the smallest free count, using the encoding 0 = reorder buffer, 1 = issue queue, 2 = load/store queue. On a tie the lowest code wins.
- R5: If the smallest free count is ≤ 0 and avail_cnt > 0, then grant_cnt and take_cnt are 0, block_o is 1, and the full-event counter selected by lim_src rises by one at the next edge.
- R6: grant_cnt never exceeds a positive smallest free count. When that budget stops the walk at a live slot, block_o is 1 and the full-event counter of lim_src rises by one. The credit limit is checked before the width limit.
- R7: grant_cnt never exceeds RENAME_W − slots_taken, saturating at 0. Live slots left over because of this limit raise block_o and count no full event.
- R8: The walk stops at the first live slot whose destination count, added to the counts of the slots already renamed, exceeds free_pregs. The destination count of slot i is slot_dst_cnt[i*2 +: 2].
- R9: A squashed slot (slot_squashed[i]) adds to take_cnt but not to grant_cnt, and uses no credit, width or registers. block_o is 1 exactly when take_cnt < avail_cnt.
- R10: At each edge the in-flight counter becomes in-flight + grant_cnt − disp_cnt, clamped at 0. The memory in-flight counter does the same with the renamed slots that have slot_is_mem set and with disp_mem_cnt.
- R11: With avail_cnt = 0 the outputs are grant_cnt = 0, take_cnt = 0 and block_o = 0, and no event is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avail_cnt | input | NW | Number of valid slots this cycle |
| slot_squashed | input | SLOTS | Per-slot squashed flag |
| slot_is_mem | input | SLOTS | Per-slot memory-instruction flag |
| slot_dst_cnt | input | SLOTS*DW | Per-slot destination-register count |
| free_pregs | input | FPW | Free physical registers |
| slots_taken | input | WUW | Rename slots already used by other threads this cycle |
| disp_cnt | input | NW | Instructions dispatched, as reported this cycle |
| disp_mem_cnt | input | NW | Memory instructions dispatched, as reported this cycle |
| rob_upd_vld | input | 1 | Reorder-buffer credit update valid |
| rob_upd_free | input | CW | New reorder-buffer credit |
| rob_upd_empty | input | 1 | Reorder-buffer empty flag carried with the update |
| iq_upd_vld | input | 1 | Issue-queue credit update valid |
| iq_upd_free | input | CW | New issue-queue credit |
| lsq_upd_vld | input | 1 | Load/store credit update valid |
| lsq_upd_free | input | CW | New load/store credit |
| grant_cnt | output | NW | Instructions renamed this cycle |
| take_cnt | output | NW | Slots removed this cycle (renamed plus squashed) |
| block_o | output | 1 | Slots left over; the thread must stall |
| lim_src | output | 2 | Limiting resource code |
| rob_empty | output | 1 | Stored reorder-buffer-empty flag |
| inflight_cnt | output | IW | Renamed but not yet dispatched instructions |
| evt_rob_cnt | output | EVW | Full events charged to the reorder buffer |
| evt_iq_cnt | output | EVW | Full events charged to the issue queue |
| evt_lsq_cnt | output | EVW | Full events charged to the load/store queue |

## Verification
Dispatch feedback and renaming happen in the same cycle. The in-flight count that a cycle's budget depends on is raised by that cycle's grant and lowered by that cycle's dispatch report. The bench drives a non-zero dispatch count while slots are being renamed. It checks that the free count gives back the dispatched credits at once and that the next cycle's in-flight value reflects both changes. A credit reload also lands while the old credit is still limiting the current grant, and the bench checks that the new value only takes effect one cycle later.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  typedef enum logic [1:0] {
    SRC_ROB = 2'd0,
    SRC_IQ  = 2'd1,
    SRC_LSQ = 2'd2
  } src_e;
endpackage

// File: rtl/rcl_credit_store.sv
module rcl_credit_store #(
  parameter int CW       = 6,
  parameter int ROB_INIT = 32,
  parameter int IQ_INIT  = 16,
  parameter int LSQ_INIT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           upd_vld,
  input  logic [2:0][CW-1:0]   upd_free,
  input  logic                 upd_empty,
  output logic [2:0][CW-1:0]   credit_q,
  output logic                 empty_q
);
  function automatic logic [CW-1:0] init_of(input int k);
    case (k)
      0:       return CW'(ROB_INIT);
      1:       return CW'(IQ_INIT);
      default: return CW'(LSQ_INIT);
    endcase
  endfunction

  for (genvar k = 0; k < 3; k++) begin : g_cred
    logic [CW-1:0] credit_d;
    always_comb begin
      credit_d = credit_q[k];
      if (upd_vld[k]) credit_d = upd_free[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          credit_q[k] <= init_of(k);
      else if (upd_vld[k]) credit_q[k] <= credit_d;
    end

    p_credit_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld[k] |=> credit_q[k] == $past(upd_free[k]));
    p_credit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_vld[k] |=> $stable(credit_q[k]));
  end

  logic empty_d;
  always_comb begin
    empty_d = empty_q;
    if (upd_vld[0]) empty_d = upd_empty;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          empty_q <= 1'b1;
    else if (upd_vld[0]) empty_q <= empty_d;
  end
endmodule

// File: rtl/rcl_inflight_track.sv
module rcl_inflight_track #(
  parameter int IW = 7,
  parameter int NW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0][NW-1:0]  add_cnt,
  input  logic [1:0][NW-1:0]  sub_cnt,
  output logic [1:0][IW-1:0]  cnt_q
);
  // index 0: all renamed instructions, index 1: memory instructions only
  for (genvar k = 0; k < 2; k++) begin : g_trk
    logic [IW-1:0] cnt_d;
    logic          cnt_en;
    always_comb begin
      int nxt;
      nxt = int'(cnt_q[k]) + int'(add_cnt[k]) - int'(sub_cnt[k]);
      if (nxt < 0) nxt = 0;
      cnt_d  = IW'(nxt);
      cnt_en = (add_cnt[k] != '0) || (sub_cnt[k] != '0);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[k] <= '0;
      else if (cnt_en) cnt_q[k] <= cnt_d;
    end

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (add_cnt[k] == '0 && sub_cnt[k] == '0) |=> $stable(cnt_q[k]));
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q[k]) < int'(sub_cnt[k]) && add_cnt[k] == '0) |=> cnt_q[k] == '0);
  end
endmodule

// File: rtl/rcl_limit_select.sv
module rcl_limit_select
  import rcl_pkg::*;
#(
  parameter int CW = 6,
  parameter int IW = 7,
  parameter int NW = 3,
  parameter int SW = 10
) (
  input  logic [2:0][CW-1:0]  credit,
  input  logic [1:0][IW-1:0]  inflight,
  input  logic [NW-1:0]       disp_all,
  input  logic [NW-1:0]       disp_mem,
  output logic signed [SW-1:0] min_free,
  output src_e                 min_src
);
  logic signed [2:0][SW-1:0] free_v;

  for (genvar k = 0; k < 3; k++) begin : g_free
    localparam int SEL = (k == 2) ? 1 : 0;
    logic [NW-1:0] back;
    assign back = (k == 2) ? disp_mem : disp_all;
    assign free_v[k] = $signed(SW'(credit[k])) - $signed(SW'(inflight[SEL]))
                     + $signed(SW'(back));
  end

  // strict compares keep the lower code on ties
  always_comb begin
    min_free = free_v[0];
    min_src  = SRC_ROB;
    if ($signed(free_v[1]) < min_free) begin
      min_free = free_v[1];
      min_src  = SRC_IQ;
    end
    if ($signed(free_v[2]) < min_free) begin
      min_free = free_v[2];
      min_src  = SRC_LSQ;
    end
  end
endmodule

// File: rtl/rcl_slot_walk.sv
module rcl_slot_walk #(
  parameter int SLOTS    = 4,
  parameter int NW       = 3,
  parameter int DW       = 2,
  parameter int FPW      = 7,
  parameter int RENAME_W = 4,
  parameter int WUW      = 3,
  parameter int SW       = 10
) (
  input  logic [NW-1:0]        avail,
  input  logic [SLOTS-1:0]     sq,
  input  logic [SLOTS-1:0]     mem,
  input  logic [SLOTS*DW-1:0]  dst,
  input  logic [FPW-1:0]       fpr,
  input  logic [WUW-1:0]       wused,
  input  logic signed [SW-1:0] min_free,
  output logic [NW-1:0]        grant,
  output logic [NW-1:0]        take,
  output logic [NW-1:0]        mem_grant,
  output logic                 credit_stop,
  output logic                 exhausted
);
  always_comb begin
    int cbud, wbud, ren, tk, mg, dsum;
    logic stop;
    exhausted = (avail != '0) && (min_free <= 0);
    if (min_free <= 0)                 cbud = 0;
    else if (int'(min_free) > SLOTS)   cbud = SLOTS;
    else                               cbud = int'(min_free);
    wbud = (int'(wused) >= RENAME_W) ? 0 : RENAME_W - int'(wused);
    ren = 0; tk = 0; mg = 0; dsum = 0;
    stop = 1'b0;
    credit_stop = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!exhausted && !stop && i < int'(avail)) begin
        if (sq[i]) begin
          tk = tk + 1;
        end else if (ren >= cbud) begin
          stop = 1'b1;
          credit_stop = 1'b1;
        end else if (ren >= wbud) begin
          stop = 1'b1;
        end else if (dsum + int'(dst[i*DW +: DW]) > int'(fpr)) begin
          stop = 1'b1;
        end else begin
          ren  = ren + 1;
          tk   = tk + 1;
          dsum = dsum + int'(dst[i*DW +: DW]);
          if (mem[i]) mg = mg + 1;
        end
      end
    end
    grant     = NW'(ren);
    take      = NW'(tk);
    mem_grant = NW'(mg);
  end
endmodule

// File: rtl/rename_credit_limiter.sv
module rename_credit_limiter
  import rcl_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int RENAME_W = 4,
  parameter int CW       = 6,
  parameter int ROB_INIT = 32,
  parameter int IQ_INIT  = 16,
  parameter int LSQ_INIT = 8,
  parameter int FPW      = 7,
  parameter int DW       = 2,
  parameter int EVW      = 16,
  localparam int NW      = $clog2(SLOTS + 1),
  localparam int WUW     = $clog2(RENAME_W + 1),
  localparam int IW      = CW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NW-1:0]       avail_cnt,
  input  logic [SLOTS-1:0]    slot_squashed,
  input  logic [SLOTS-1:0]    slot_is_mem,
  input  logic [SLOTS*DW-1:0] slot_dst_cnt,
  input  logic [FPW-1:0]      free_pregs,
  input  logic [WUW-1:0]      slots_taken,
  input  logic [NW-1:0]       disp_cnt,
  input  logic [NW-1:0]       disp_mem_cnt,
  input  logic                rob_upd_vld,
  input  logic [CW-1:0]       rob_upd_free,
  input  logic                rob_upd_empty,
  input  logic                iq_upd_vld,
  input  logic [CW-1:0]       iq_upd_free,
  input  logic                lsq_upd_vld,
  input  logic [CW-1:0]       lsq_upd_free,
  output logic [NW-1:0]       grant_cnt,
  output logic [NW-1:0]       take_cnt,
  output logic                block_o,
  output logic [1:0]          lim_src,
  output logic                rob_empty,
  output logic [IW-1:0]       inflight_cnt,
  output logic [EVW-1:0]      evt_rob_cnt,
  output logic [EVW-1:0]      evt_iq_cnt,
  output logic [EVW-1:0]      evt_lsq_cnt
);
  localparam int SW = IW + 3;

  logic [2:0][CW-1:0]   credit_q;
  logic [1:0][IW-1:0]   infl_q;
  logic signed [SW-1:0] min_free;
  src_e                 min_src;
  logic [NW-1:0]        mem_grant;
  logic                 credit_stop, exhausted, full_evt;

  rcl_credit_store #(
    .CW(CW), .ROB_INIT(ROB_INIT), .IQ_INIT(IQ_INIT), .LSQ_INIT(LSQ_INIT)
  ) u_credit (
    .clk(clk), .rst_n(rst_n),
    .upd_vld({lsq_upd_vld, iq_upd_vld, rob_upd_vld}),
    .upd_free({lsq_upd_free, iq_upd_free, rob_upd_free}),
    .upd_empty(rob_upd_empty),
    .credit_q(credit_q),
    .empty_q(rob_empty)
  );

  rcl_inflight_track #(.IW(IW), .NW(NW)) u_infl (
    .clk(clk), .rst_n(rst_n),
    .add_cnt({mem_grant, grant_cnt}),
    .sub_cnt({disp_mem_cnt, disp_cnt}),
    .cnt_q(infl_q)
  );

  rcl_limit_select #(.CW(CW), .IW(IW), .NW(NW), .SW(SW)) u_sel (
    .credit(credit_q), .inflight(infl_q),
    .disp_all(disp_cnt), .disp_mem(disp_mem_cnt),
    .min_free(min_free), .min_src(min_src)
  );

  rcl_slot_walk #(
    .SLOTS(SLOTS), .NW(NW), .DW(DW), .FPW(FPW),
    .RENAME_W(RENAME_W), .WUW(WUW), .SW(SW)
  ) u_walk (
    .avail(avail_cnt), .sq(slot_squashed), .mem(slot_is_mem),
    .dst(slot_dst_cnt), .fpr(free_pregs), .wused(slots_taken),
    .min_free(min_free),
    .grant(grant_cnt), .take(take_cnt), .mem_grant(mem_grant),
    .credit_stop(credit_stop), .exhausted(exhausted)
  );

  assign block_o      = (take_cnt < avail_cnt);
  assign lim_src      = min_src;
  assign inflight_cnt = infl_q[0];
  assign full_evt     = exhausted || credit_stop;

  logic [2:0][EVW-1:0] evt_q;
  for (genvar k = 0; k < 3; k++) begin : g_evt
    logic           evt_en;
    logic [EVW-1:0] evt_d;
    assign evt_en = full_evt && (int'(min_src) == k);
    assign evt_d  = evt_q[k] + EVW'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      evt_q[k] <= '0;
      else if (evt_en) evt_q[k] <= evt_d;
    end
  end
  assign evt_rob_cnt = evt_q[0];
  assign evt_iq_cnt  = evt_q[1];
  assign evt_lsq_cnt = evt_q[2];

  p_grant_credit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (min_free > 0) |-> (int'(grant_cnt) <= int'(min_free)));
  p_exhaust_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (min_free <= 0) |-> (take_cnt == '0 && grant_cnt == '0));
  p_take_ge_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_cnt >= grant_cnt);
  p_grant_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slots_taken) <= RENAME_W) |-> (int'(grant_cnt) + int'(slots_taken) <= RENAME_W));
  p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[0] != {EVW{1'b1}} && evt_q[1] != {EVW{1'b1}} && evt_q[2] != {EVW{1'b1}})
    |=> ($countones({evt_q[0] != $past(evt_q[0]), evt_q[1] != $past(evt_q[1]),
                     evt_q[2] != $past(evt_q[2])}) <= 1));
endmodule

// File: tb/rename_credit_limiter_tb_top.sv
module rename_credit_limiter_tb_top;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 4;
  localparam int RW     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  avail_cnt = '0;
  logic [3:0]  slot_squashed = '0, slot_is_mem = '0;
  logic [7:0]  slot_dst_cnt = '0;
  logic [6:0]  free_pregs = '0;
  logic [2:0]  slots_taken = '0, disp_cnt = '0, disp_mem_cnt = '0;
  logic        rob_upd_vld = 1'b0, rob_upd_empty = 1'b0, iq_upd_vld = 1'b0, lsq_upd_vld = 1'b0;
  logic [5:0]  rob_upd_free = '0, iq_upd_free = '0, lsq_upd_free = '0;
  logic [2:0]  grant_cnt, take_cnt;
  logic        block_o, rob_empty;
  logic [1:0]  lim_src;
  logic [6:0]  inflight_cnt;
  logic [15:0] evt_rob_cnt, evt_iq_cnt, evt_lsq_cnt;

  always #(PERIOD/2) clk = ~clk;

  rename_credit_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .avail_cnt(avail_cnt), .slot_squashed(slot_squashed),
    .slot_is_mem(slot_is_mem), .slot_dst_cnt(slot_dst_cnt), .free_pregs(free_pregs),
    .slots_taken(slots_taken), .disp_cnt(disp_cnt), .disp_mem_cnt(disp_mem_cnt),
    .rob_upd_vld(rob_upd_vld), .rob_upd_free(rob_upd_free), .rob_upd_empty(rob_upd_empty),
    .iq_upd_vld(iq_upd_vld), .iq_upd_free(iq_upd_free), .lsq_upd_vld(lsq_upd_vld),
    .lsq_upd_free(lsq_upd_free), .grant_cnt(grant_cnt), .take_cnt(take_cnt),
    .block_o(block_o), .lim_src(lim_src), .rob_empty(rob_empty),
    .inflight_cnt(inflight_cnt), .evt_rob_cnt(evt_rob_cnt), .evt_iq_cnt(evt_iq_cnt),
    .evt_lsq_cnt(evt_lsq_cnt)
  );

  typedef struct {
    string tag;
    int g, t, b, l, infl, remp, e0, e1, e2;
  } exp_t;
  exp_t sb_q[$];

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench model state, built from the requirements
  int rc = 32, ic = 16, lc = 8, remp = 1, inf = 0, mi = 0;
  int ev[3] = '{0, 0, 0};

  task automatic chk(string tag, string fld, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  task automatic step(string tag, int av, logic [3:0] sq, logic [3:0] mm,
                      logic [7:0] dst, int fpr, int wu, int dp, int dm,
                      logic [2:0] uv, int ur, int ui, int ul, bit ue);
    int fr, fi, fl, mn, ls, cb, wb, g, t, mg, ds;
    bit stop, cs, exh;
    exp_t e;
    @(negedge clk);
    avail_cnt = 3'(av); slot_squashed = sq; slot_is_mem = mm; slot_dst_cnt = dst;
    free_pregs = 7'(fpr); slots_taken = 3'(wu); disp_cnt = 3'(dp); disp_mem_cnt = 3'(dm);
    rob_upd_vld = uv[0]; iq_upd_vld = uv[1]; lsq_upd_vld = uv[2];
    rob_upd_free = 6'(ur); iq_upd_free = 6'(ui); lsq_upd_free = 6'(ul); rob_upd_empty = ue;
    fr = rc - (inf - dp); fi = ic - (inf - dp); fl = lc - (mi - dm);
    mn = fr; ls = 0;
    if (fi < mn) begin mn = fi; ls = 1; end
    if (fl < mn) begin mn = fl; ls = 2; end
    exh = (av > 0) && (mn <= 0);
    cb = (mn <= 0) ? 0 : ((mn > SLOTS) ? SLOTS : mn);
    wb = (wu >= RW) ? 0 : RW - wu;
    g = 0; t = 0; mg = 0; ds = 0; stop = 0; cs = 0;
    if (!exh) begin
      for (int i = 0; i < av; i++) begin
        if (!stop) begin
          if (sq[i]) t++;
          else if (g >= cb) begin stop = 1; cs = 1; end
          else if (g >= wb) stop = 1;
          else if (ds + int'(dst[i*2 +: 2]) > fpr) stop = 1;
          else begin
            g++; t++; ds += int'(dst[i*2 +: 2]);
            if (mm[i]) mg++;
          end
        end
      end
    end
    e.tag = tag; e.g = g; e.t = t; e.b = (t < av) ? 1 : 0; e.l = ls;
    e.infl = inf; e.remp = remp; e.e0 = ev[0]; e.e1 = ev[1]; e.e2 = ev[2];
    sb_q.push_back(e);
    if (exh || cs) ev[ls]++;
    inf = inf + g - dp;  if (inf < 0) inf = 0;
    mi  = mi + mg - dm;  if (mi < 0) mi = 0;
    if (uv[0]) begin rc = ur; remp = ue; end
    if (uv[1]) ic = ui;
    if (uv[2]) lc = ul;
  endtask

  // monitor: compares just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/2 - 1);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "grant R6", int'(grant_cnt), e.g);
        chk(e.tag, "take R9", int'(take_cnt), e.t);
        chk(e.tag, "block R7", int'(block_o), e.b);
        chk(e.tag, "lim R4", int'(lim_src), e.l);
        chk(e.tag, "inflight R10", int'(inflight_cnt), e.infl);
        chk(e.tag, "rob_empty R2", int'(rob_empty), e.remp);
        chk(e.tag, "evt_rob R5", int'(evt_rob_cnt), e.e0);
        chk(e.tag, "evt_iq R5", int'(evt_iq_cnt), e.e1);
        chk(e.tag, "evt_lsq R5", int'(evt_lsq_cnt), e.e2);
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "inflight", int'(inflight_cnt), 0);
    chk("R1", "rob_empty", int'(rob_empty), 1);
    chk("R1", "evt_rob", int'(evt_rob_cnt), 0);
    chk("R1", "evt_iq", int'(evt_iq_cnt), 0);
    chk("R1", "evt_lsq", int'(evt_lsq_cnt), 0);
    chk("R1", "lim (credits 32/16/8)", int'(lim_src), 2);

    // R11: nothing offered
    step("R11", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    // R4: full group, load/store credit smallest
    step("R4", 4, 4'b0000, 4'b0101, 8'h55, 20, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    // R2: reload all three, empty flag cleared
    step("R2", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b111, 5, 5, 9, 0);
    // R6: tie between reorder buffer and issue queue, credit budget of one
    step("R6", 3, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    // R3: dispatch feedback returns credit in the same cycle
    step("R3", 2, 4'b0000, 4'b0000, 8'h05, 20, 0, 3, 2, 3'b000, 0, 0, 0, 0);
    // R2: only the reorder-buffer update is valid; issue-queue value ignored
    step("R2", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b001, 4, 60, 60, 1);
    // R5: no reorder-buffer room left
    step("R5", 2, 4'b0000, 4'b0000, 8'h05, 20, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    step("R2", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b111, 30, 30, 30, 0);
    // R7: width limited by other threads
    step("R7", 4, 4'b0000, 4'b0000, 8'h55, 20, 3, 0, 0, 3'b000, 0, 0, 0, 0);
    // R8: physical registers run out at slot 2
    step("R8", 4, 4'b0000, 4'b0000, 8'b10_01_10_10, 4, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    // R9: squashed slots removed at no cost, width of two
    step("R9", 4, 4'b0101, 4'b1111, 8'h55, 20, 2, 0, 0, 3'b000, 0, 0, 0, 0);
    // R10: dispatch larger than in-flight clamps at zero
    step("R10", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 7, 7, 3'b000, 0, 0, 0, 0);
    step("R10", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 5, 3, 3'b000, 0, 0, 0, 0);
    step("R10", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b100, 0, 0, 1, 0);
    // R6: load/store limited, event charged to load/store
    step("R6", 3, 4'b0000, 4'b0111, 8'h15, 20, 0, 0, 0, 3'b110, 0, 1, 30, 0);
    // R6: issue queue limited, concurrent dispatch
    step("R6", 3, 4'b0000, 4'b0000, 8'h15, 20, 0, 1, 1, 3'b000, 0, 0, 0, 0);
    step("R5", 2, 4'b0010, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    step("R11", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    step("R11", 0, 4'b0000, 4'b0000, 8'h00, 20, 0, 0, 0, 3'b000, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule